// File: doc/BRIEF.md
# LCD Multiplex Drive Level Sequencer

This block turns a frame-rate step signal, a drive mode and a bias choice into a 2-bit level code for each of four backplane pins and 24 segment pins of a low-multiplex liquid crystal panel. An analog selector outside the block turns each code into one of the four supply or bias voltages. The block supports static drive and 1:2, 1:3 and 1:4 multiplex drive, with either a three-step (1/3) or a midpoint (1/2) bias ladder. This gives up to 96 addressable picture elements.

A frame is cut into N backplane slots, where N is the multiplex ratio. In each slot, one backplane takes an outer level. A segment whose bit is set for that backplane takes the opposite outer level, and every other pin sits on an inner level. After each full frame, the polarity of every pin inverts, so no element sees a lasting DC voltage. The segment bits are sampled every clock and change the codes at once, so the host may rewrite them at any time. The codes are continuous levels rather than a data stream, so every pin is plain and none has a handshake.

Top module: `lcdseq_top`

## Requirements
- R1: While `rst_n` is low, every backplane and segment code is 3 (VLCD). After reset the sequencer is in 1:4 multiplex, 1/3 bias, at slot 0 with positive polarity.
- R2: Mode codes are 0 = static, 1 = 1:2, 2 = 1:3 and 3 = 1:4, so N = mode + 1. Each clock with `tick` high moves the slot on by one. After slot N-1 the slot returns to 0. With `tick` low the slot and the polarity hold.
- R3: Polarity flips each time the slot wraps from N-1 to 0. When `mode` or `half_bias` differs from the value in use, the sequencer adopts the new setting on the next clock and restarts at slot 0 with positive polarity. A restart wins over a simultaneous `tick`.
- R4: Level codes are 0 = VDD, 1 = upper inner level (or the midpoint under 1/2 bias), 2 = lower inner level and 3 = VLCD. Outputs are registered: the codes after a clock edge reflect the sequencer state and `seg_bits` present before that edge.
- R5: Multiplex with 1/3 bias, positive polarity: the backplane of the current slot drives 0 and the other backplanes drive 2. A segment whose bit is set for the current slot drives 3, and a clear one drives 1. Under negative polarity every code c becomes 3-c.
- R6: Multiplex with 1/2 bias, positive polarity: the current backplane drives 0 and the others drive 1. A set segment drives 3, and a clear one drives 0. Under negative polarity 0 and 3 swap and 1 stays 1. Code 2 never appears.
- R7: In static mode the bias setting is ignored. Every backplane drives 0 under positive polarity and 3 under negative polarity. A segment whose row-0 bit is set drives the opposite code, and a clear one drives the same code as the backplane.
- R8: A backplane k with k >= N copies the code of backplane (k mod N).
- R9: Segment bits of rows other than the current slot, including every row >= N, have no effect on any output.
- R10: `seg_bits[r*24 + j]` is the bit of segment j for backplane row r. Backplane k's code is at `bp_lvl[2k+1:2k]`, and segment j's code is at `seg_lvl[2j+1:2j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse that advances the slot |
| mode | input | 2 | Multiplex ratio minus one (0 static .. 3 for 1:4) |
| half_bias | input | 1 | 1 selects the 1/2 bias ladder, 0 the 1/3 ladder |
| seg_bits | input | 96 | Segment on/off bits, row-major by backplane |
| bp_lvl | output | 8 | Backplane level codes, 2 bits per backplane |
| seg_lvl | output | 48 | Segment level codes, 2 bits per segment |

## Verification
The bench targets several corner cases:
- **Slot wrap in each mode.** An off-by-one in the wrap would stretch a 1:3 frame to four slots, and polarity would then flip late.
- **Mode or bias change together with a tick.** A design that let the tick win would start the new mode at slot 1, or leave the slot above the new N.
- **Polarity inversion under 1/2 bias.** The midpoint must stay at 1. A plain bitwise inversion would produce the unused code 2.
- **Spare backplanes and ignored rows.** The bench changes only the ignored rows while tick is low and expects identical outputs. A wrong row select or a missing mirror shows up as a changed segment code or a spare backplane stuck at an inner level.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LV_VDD  = 2'd0;
  localparam lvl_t LV_HI   = 2'd1;
  localparam lvl_t LV_LO   = 2'd2;
  localparam lvl_t LV_VLCD = 2'd3;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_2      = 2'd1,
    MUX_3      = 2'd2,
    MUX_4      = 2'd3
  } mux_e;

  // Negative-polarity counterpart of a level: mirror about the ladder
  // centre; the 1/2-bias midpoint is its own mirror.
  function automatic lvl_t flip_lvl(input lvl_t c, input logic half);
    if (half && c == LV_HI) return LV_HI;
    return ~c;
  endfunction

endpackage

// File: rtl/lcdseq_timing.sv
module lcdseq_timing
  import lcdseq_pkg::*;
#(
  parameter int NUM_BP = 4,
  localparam int SW = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    mode_i,
  input  logic          half_i,
  output logic [SW-1:0] slot_o,
  output logic          phase_o,
  output logic [1:0]    mode_o,
  output logic          half_o
);

  logic [SW-1:0] slot_q;
  logic          phase_q;
  logic [1:0]    mode_q;
  logic          half_q;
  logic          resync;
  logic          last_slot;

  assign resync    = (mode_i != mode_q) || (half_i != half_q);
  assign last_slot = (slot_q == SW'(mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      phase_q <= 1'b0;
      mode_q  <= MUX_4;
      half_q  <= 1'b0;
    end else if (resync) begin
      mode_q  <= mode_i;
      half_q  <= half_i;
      slot_q  <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      if (last_slot) begin
        slot_q  <= '0;
        phase_q <= ~phase_q;
      end else begin
        slot_q  <= slot_q + 1'b1;
      end
    end
  end

  assign slot_o  = slot_q;
  assign phase_o = phase_q;
  assign mode_o  = mode_q;
  assign half_o  = half_q;

  // R2: slot never exceeds the active ratio
  p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SW'(mode_q));

  // R2: a tick inside a frame steps the slot by exactly one
  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !resync && !last_slot) |=>
      (slot_q == SW'($past(slot_q) + 1'b1)) && $stable(phase_q));

  // R2: without tick or change, state holds
  p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !resync) |=> $stable(slot_q) && $stable(phase_q));

  // R3: frame wrap flips polarity
  p_wrap_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !resync && last_slot) |=>
      (slot_q == '0) && (phase_q != $past(phase_q)));

  // R3: setting change restarts the frame, ahead of tick
  p_resync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (slot_q == '0) && !phase_q && (mode_q == $past(mode_i)));

endmodule

// File: rtl/lcdseq_bp_lane.sv
module lcdseq_bp_lane
  import lcdseq_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int IDX    = 0,
  localparam int SW = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic [SW-1:0] slot,
  input  logic          phase,
  input  logic [1:0]    mode,
  input  logic          half,
  output lvl_t          lvl
);

  logic [SW-1:0] eff;
  logic          active;
  lvl_t          base;

  // Spare backplanes follow the backplane of the same residue.
  always_comb begin
    unique case (mode)
      MUX_STATIC: eff = '0;
      MUX_2:      eff = SW'(IDX % 2);
      MUX_3:      eff = SW'(IDX % 3);
      default:    eff = SW'(IDX);
    endcase
  end

  assign active = (eff == slot);

  always_comb begin
    if (active)    base = LV_VDD;
    else if (half) base = LV_HI;
    else           base = LV_LO;
    lvl = phase ? flip_lvl(base, half) : base;
  end

endmodule

// File: rtl/lcdseq_seg_lane.sv
module lcdseq_seg_lane
  import lcdseq_pkg::*;
#(
  parameter int NUM_BP = 4,
  localparam int SW = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic [NUM_BP-1:0] col_bits,
  input  logic [SW-1:0]     slot,
  input  logic              phase,
  input  logic [1:0]        mode,
  input  logic              half,
  output lvl_t              lvl
);

  logic two_level;
  lvl_t base;

  assign two_level = (mode == MUX_STATIC) || half;

  always_comb begin
    if (col_bits[slot]) base = LV_VLCD;
    else if (two_level) base = LV_VDD;
    else                base = LV_HI;
    lvl = phase ? flip_lvl(base, half) : base;
  end

endmodule

// File: rtl/lcdseq_top.sv
module lcdseq_top
  import lcdseq_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_SEG = 24,
  localparam int SW     = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int BITS_W = NUM_BP * NUM_SEG,
  localparam int NPIN   = NUM_BP + NUM_SEG
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [1:0]                mode,
  input  logic                      half_bias,
  input  logic [BITS_W-1:0]         seg_bits,
  output logic [NUM_BP*LVL_W-1:0]   bp_lvl,
  output logic [NUM_SEG*LVL_W-1:0]  seg_lvl
);

  logic [SW-1:0] cur_slot;
  logic          cur_phase;
  logic [1:0]    cur_mode;
  logic          cur_half;

  lvl_t bp_nxt  [NUM_BP];
  lvl_t seg_nxt [NUM_SEG];
  lvl_t bp_q    [NUM_BP];
  lvl_t seg_q   [NUM_SEG];

  lcdseq_timing #(.NUM_BP(NUM_BP)) u_timing (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mode_i  (mode),
    .half_i  (half_bias),
    .slot_o  (cur_slot),
    .phase_o (cur_phase),
    .mode_o  (cur_mode),
    .half_o  (cur_half)
  );

  for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
    lcdseq_bp_lane #(.NUM_BP(NUM_BP), .IDX(k)) u_lane (
      .slot  (cur_slot),
      .phase (cur_phase),
      .mode  (cur_mode),
      .half  (cur_half),
      .lvl   (bp_nxt[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bp_q[k] <= LV_VLCD;
      else        bp_q[k] <= bp_nxt[k];
    end

    assign bp_lvl[LVL_W*k +: LVL_W] = bp_q[k];
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    logic [NUM_BP-1:0] col;
    for (genvar r = 0; r < NUM_BP; r++) begin : g_row
      assign col[r] = seg_bits[r*NUM_SEG + j];
    end

    lcdseq_seg_lane #(.NUM_BP(NUM_BP)) u_lane (
      .col_bits (col),
      .slot     (cur_slot),
      .phase    (cur_phase),
      .mode     (cur_mode),
      .half     (cur_half),
      .lvl      (seg_nxt[j])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[j] <= LV_VLCD;
      else        seg_q[j] <= seg_nxt[j];
    end

    assign seg_lvl[LVL_W*j +: LVL_W] = seg_q[j];
  end

  // Observation vectors for the checks below
  logic [NUM_BP-1:0] outer_bp;
  logic [NPIN-1:0]   lo_hit;
  logic [NPIN-1:0]   inner_hit;

  for (genvar k = 0; k < NUM_BP; k++) begin : g_obs_bp
    assign outer_bp[k]  = (2'(k) <= cur_mode) &&
                          (bp_nxt[k] == LV_VDD || bp_nxt[k] == LV_VLCD);
    assign lo_hit[k]    = (bp_nxt[k] == LV_LO);
    assign inner_hit[k] = (bp_nxt[k] == LV_LO) || (bp_nxt[k] == LV_HI);
  end
  for (genvar j = 0; j < NUM_SEG; j++) begin : g_obs_seg
    assign lo_hit[NUM_BP+j]    = (seg_nxt[j] == LV_LO);
    assign inner_hit[NUM_BP+j] = (seg_nxt[j] == LV_LO) || (seg_nxt[j] == LV_HI);
  end

  // R5: in multiplex exactly one live backplane sits on an outer level
  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != MUX_STATIC) |-> ($countones(outer_bp) == 1));

  // R6: the half-bias ladder has no lower inner level
  p_half_no_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_half |-> (lo_hit == '0));

  // R7: static drive uses only the two rails
  p_static_rails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MUX_STATIC) |-> (inner_hit == '0));

  // R4: registered outputs follow the lane results one clock later
  p_out_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bp_lvl[LVL_W-1:0] == $past(bp_nxt[0])));

endmodule

// File: tb/sim_lcdseq_top.sv
module sim_lcdseq_top;

  localparam int NB = 4;
  localparam int NS = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    mode = 2'd3;
  logic          half_bias = 1'b0;
  logic [NB*NS-1:0] seg_bits = '0;
  logic [2*NB-1:0]  bp_lvl;
  logic [2*NS-1:0]  seg_lvl;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lcdseq_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (mode),
    .half_bias (half_bias),
    .seg_bits  (seg_bits),
    .bp_lvl    (bp_lvl),
    .seg_lvl   (seg_lvl)
  );

  // ---------------- behavioural reference ----------------
  int m_mode = 3, m_bias = 0, m_slot = 0, m_phase = 0;
  logic [2*NB-1:0] exp_bp  = '1;
  logic [2*NS-1:0] exp_seg = '1;

  function automatic int mirror(int v, int half, int ph);
    if (!ph) return v;
    if (half && v == 1) return 1;
    return 3 - v;
  endfunction

  function automatic int ref_bp(int k);
    int n, base;
    n = m_mode + 1;
    if ((k % n) == m_slot) base = 0;
    else base = m_bias ? 1 : 2;
    return mirror(base, m_bias, m_phase);
  endfunction

  function automatic int ref_seg(int j, logic [NB*NS-1:0] bits);
    int base;
    if (bits[m_slot*NS + j]) base = 3;
    else if (m_mode == 0 || m_bias != 0) base = 0;
    else base = 1;
    return mirror(base, (m_mode == 0) ? 0 : m_bias, m_phase);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 3; m_bias = 0; m_slot = 0; m_phase = 0;
      exp_bp = '1; exp_seg = '1;
    end else begin
      for (int k = 0; k < NB; k++) exp_bp[2*k +: 2] = 2'(ref_bp(k));
      for (int j = 0; j < NS; j++) exp_seg[2*j +: 2] = 2'(ref_seg(j, seg_bits));
      if (int'(mode) != m_mode || int'(half_bias) != m_bias) begin
        m_mode = int'(mode); m_bias = int'(half_bias);
        m_slot = 0; m_phase = 0;
      end else if (tick) begin
        if (m_slot == m_mode) begin m_slot = 0; m_phase ^= 1; end
        else m_slot++;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic compare(input string tag);
    checks++;
    if (bp_lvl !== exp_bp || seg_lvl !== exp_seg) begin
      fails++;
      $display("FAIL %s bp=%h/%h seg=%h/%h (actual/expected)",
               tag, bp_lvl, exp_bp, seg_lvl, exp_seg);
    end
  endtask

  task automatic run(input int n, input string tag, input int tick_pct, input int seg_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
      tick = (($urandom % 100) < tick_pct);
      if (seg_every > 0 && (i % seg_every) == 0)
        seg_bits = {$urandom, $urandom, $urandom};
    end
  endtask

  function automatic string mode_tag(int md, int hb);
    if (md == 0) return "R7 R10";
    if (hb != 0) return "R6 R8";
    return "R5 R8";
  endfunction

  initial begin
    logic [2*NB-1:0] snap_bp;
    logic [2*NS-1:0] snap_seg;

    // R1: reset levels
    seg_bits = {$urandom, $urandom, $urandom};
    run(4, "R1", 50, 0);
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    // R1: default 1:4, 1/3 bias from slot 0 positive polarity
    run(6, "R1", 0, 0);

    // R2 R3: stepping and wrap with ticks on every clock
    run(24, "R2 R3", 100, 3);

    // every mode and bias, sparse ticks, changing segment data (R4 R10)
    for (int md = 0; md < 4; md++) begin
      for (int hb = 0; hb < 2; hb++) begin
        mode = 2'(md);
        half_bias = hb[0];
        run(60, mode_tag(md, hb), 40, 5);
        run(20, "R4", 100, 1);
      end
    end

    // R3: setting change on the same clock as a tick, mid-frame
    mode = 2'd3; half_bias = 1'b0;
    run(10, "R3", 100, 0);
    for (int t = 0; t < 6; t++) begin
      mode = 2'((t + 1) % 4);
      half_bias = t[0];
      tick = 1'b1;
      run(1, "R3", 100, 0);
      run(7, "R3", 100, 2);
    end

    // R7: static with 1/2 bias must equal static with 1/3 bias
    mode = 2'd0; half_bias = 1'b1;
    run(12, "R7", 50, 2);

    // R9: rows other than the active one, in 1:2 mode, change alone
    mode = 2'd1; half_bias = 1'b0;
    run(9, "R9", 50, 3);
    tick = 1'b0;
    @(negedge clk);
    compare("R9");
    @(negedge clk);
    compare("R9");
    snap_bp = bp_lvl;
    snap_seg = seg_lvl;
    for (int r = 0; r < NB; r++)
      if (r != m_slot)
        for (int j = 0; j < NS; j++) seg_bits[r*NS + j] = ~seg_bits[r*NS + j];
    @(negedge clk);
    compare("R9");
    checks++;
    if (bp_lvl !== snap_bp || seg_lvl !== snap_seg) begin
      fails++;
      $display("FAIL R9 ignored rows moved outputs: seg=%h expected %h", seg_lvl, snap_seg);
    end

    // R8: spare backplane mirroring in 1:3
    mode = 2'd2; half_bias = 1'b1;
    run(30, "R8", 70, 4);

    // R1: reset mid-operation
    rst_n = 1'b0;
    run(3, "R1", 50, 1);
    rst_n = 1'b1;
    mode = 2'd3; half_bias = 1'b0;
    run(12, "R1 R2", 100, 2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule